// File: doc/BRIEF.md
# Mixed-Radix Reflected Gray Sequencer

This block walks every codeword of a mixed-radix reflected Gray code whose digit k may take any value from 0 up to a multiplicity M_k. Between one codeword and the next exactly one digit moves by one, and a digit that reaches either end of its range turns round instead of wrapping. Alongside each codeword the block reports which digit moved and in which direction. It also reports the signed binomial weight, the product over all digits of (-1)^digit times C(M_k, digit). The weight is kept as an unsigned magnitude plus a sign bit. It is updated one step at a time with a multiply and a reciprocal-constant multiply, so no divider is needed.

A run is launched with `start`. The caller supplies the multiplicity vector, a trim amount that shrinks the smallest multiplicity (anchor and lane accounting), and a slice given as a first rank and a length. Several copies of the block can be given evenly spaced first ranks and the same length, and together they cover the whole sequence. Each copy first steps silently to its first rank and then streams one codeword per accepted transfer. Codewords leave on a valid/ready stream. While `out_valid` is high and `out_ready` is low, every output field holds still, and `out_valid` only falls after the final codeword of the slice has been accepted.

Top module: `mrg_sequencer`

## Requirements
- R1: After reset, `out_valid`, `busy_o` and `done_o` are all low.
- R2: Digit k sits at bits [k*MW +: MW] of `out_digits` and never exceeds the effective multiplicity. Rank 0 is the all-zero codeword, with `out_moved`=0, weight 1 and `out_neg`=0.
- R3: The codeword at rank r is built from the mixed-radix digits b_k of r, with digit 0 the least significant and radix M_k+1. Digit k equals b_k when floor(r / prod_{i<=k}(M_i+1)) is even, and M_k-b_k otherwise. Any two consecutive codewords differ in exactly one digit, by one. `out_idx` names that digit, `out_up`=1 means it rose, and `out_moved`=1 for every rank above 0.
- R4: `out_weight` equals the product of C(M_k, digit_k). `out_neg` equals the parity of the digit sum, where 1 means negative.
- R5: The trim input reduces the smallest effective multiplicity by `trim_i`, but never below 1. When several digits tie for smallest, the one with the lowest index is trimmed.
- R6: The block emits ranks `ofs_i` up to min(`ofs_i`+`len_i`, total)-1 in order, where total is the product of (M_k+1). A `len_i` of 0 means run to the end of the sequence. When `ofs_i` >= total, nothing is emitted.
- R7: `out_last` is high on the final codeword of the slice and only there. `done_o` is high for exactly one cycle, in the cycle after the final codeword is accepted, or after the silent walk runs out when nothing is emitted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields stay stable.
- R9: `busy_o` is high from the cycle after an accepted `start` until `done_o`. A `start` that arrives while busy has no effect on the stream.
- R10: A multiplicity of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run when idle |
| mult_i | input | NDIG*MW | Multiplicity per digit, digit k at bits [k*MW +: MW] |
| trim_i | input | 2 | Amount removed from the smallest multiplicity |
| ofs_i | input | NDIG*MW+1 | First rank of the slice |
| len_i | input | NDIG*MW+1 | Number of codewords in the slice, 0 = to the end |
| busy_o | output | 1 | A run is in progress |
| out_valid | output | 1 | Codeword available |
| out_ready | input | 1 | Consumer accepts the codeword |
| out_digits | output | NDIG*MW | Current codeword |
| out_idx | output | clog2(NDIG) | Digit changed by the step into this codeword |
| out_up | output | 1 | 1 when that digit rose |
| out_moved | output | 1 | 0 only for rank 0 |
| out_neg | output | 1 | Sign of the weight, 1 = negative |
| out_weight | output | WW | Magnitude of the binomial weight |
| out_last | output | 1 | Final codeword of the slice |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest weights to reach are the falling updates. These happen after a digit has turned at its top end, where the factor is digit/(M-digit+1) and the reciprocal constant must still give an exact quotient. A slice that begins deep in the sequence reaches these updates only after a long silent walk. The bench covers them by sweeping every rank of the largest configuration, where all multiplicities are at maximum, and by running a sequence as four staggered slices whose concatenation must equal the full walk. Random stalls, a trimmed and zero-clamped vector, and a start pulse injected mid-run exercise the remaining paths.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SKIP = 2'd1,
    SEQ_EMIT = 2'd2
  } seq_state_e;

  // Rounded-up reciprocal 2^sh / d, used for exact division by d of any x < 2^sh
  function automatic logic [63:0] recip_magic(input int sh, input int d);
    logic [63:0] num;
    num = (64'd1 << sh) + 64'(d) - 64'd1;
    return num / 64'(d);
  endfunction

endpackage

// File: rtl/gs_trim.sv
module gs_trim #(
  parameter int NDIG = 4,
  parameter int MW   = 3,
  localparam int CW  = NDIG*MW+1
) (
  input  logic [NDIG-1:0][MW-1:0] mult_i,
  input  logic [1:0]              trim_i,
  output logic [NDIG-1:0][MW-1:0] m_eff_o,
  output logic [CW-1:0]           total_o
);

  logic [NDIG-1:0][MW-1:0] clamped;
  logic [MW-1:0]           best;
  int                      best_k;
  logic [CW-1:0]           acc;

  always_comb begin
    best   = '1;
    best_k = 0;
    for (int k = 0; k < NDIG; k++) begin
      clamped[k] = (mult_i[k] == '0) ? MW'(1) : mult_i[k];
    end
    for (int k = NDIG-1; k >= 0; k--) begin
      if (clamped[k] <= best) begin
        best   = clamped[k];
        best_k = k;
      end
    end
    m_eff_o = clamped;
    for (int k = 0; k < NDIG; k++) begin
      if (k == best_k) begin
        m_eff_o[k] = (clamped[k] > MW'(trim_i)) ? clamped[k] - MW'(trim_i) : MW'(1);
      end
    end
    acc = CW'(1);
    for (int k = 0; k < NDIG; k++) begin
      acc = acc * (CW'(m_eff_o[k]) + CW'(1));
    end
    total_o = acc;
  end

endmodule

// File: rtl/gs_step.sv
module gs_step #(
  parameter int NDIG = 4,
  parameter int MW   = 3,
  localparam int FW  = $clog2(NDIG+1),
  localparam int IW  = $clog2(NDIG)
) (
  input  logic [NDIG-1:0][MW-1:0] m_i,
  input  logic [NDIG-1:0][MW-1:0] a_i,
  input  logic [NDIG-1:0]         o_i,
  input  logic [NDIG:0][FW-1:0]   f_i,
  output logic [NDIG-1:0][MW-1:0] a_o,
  output logic [NDIG-1:0]         o_o,
  output logic [NDIG:0][FW-1:0]   f_o,
  output logic [IW-1:0]           j_o,
  output logic                    up_o,
  output logic [MW-1:0]           num_o,
  output logic [MW-1:0]           den_o
);

  logic [MW-1:0] nxt;

  // Loopless step: the focus at slot 0 picks the digit, which then moves one unit
  always_comb begin
    a_o   = a_i;
    o_o   = o_i;
    f_o   = f_i;
    f_o[0] = '0;
    j_o   = '0;
    up_o  = 1'b1;
    num_o = MW'(1);
    den_o = MW'(1);
    nxt   = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (f_i[0] == FW'(k)) begin
        j_o  = IW'(k);
        up_o = o_i[k];
        if (o_i[k]) begin
          nxt   = a_i[k] + MW'(1);
          num_o = m_i[k] - nxt + MW'(1);
          den_o = nxt;
        end else begin
          nxt   = a_i[k] - MW'(1);
          num_o = a_i[k];
          den_o = m_i[k] - nxt;
        end
        a_o[k] = nxt;
        if (nxt == '0 || nxt == m_i[k]) begin
          o_o[k]   = ~o_i[k];
          f_o[k]   = f_i[k+1];
          f_o[k+1] = FW'(k+1);
        end
      end
    end
  end

endmodule

// File: rtl/gs_weight.sv
module gs_weight
  import mrg_pkg::*;
#(
  parameter int MW  = 3,
  parameter int WW  = 24,
  localparam int XW = WW+MW,
  localparam int SH = XW,
  localparam int MMAX = (1 << MW) - 1,
  localparam int PW = XW+SH+1
) (
  input  logic [WW-1:0] w_i,
  input  logic [MW-1:0] num_i,
  input  logic [MW-1:0] den_i,
  output logic [WW-1:0] w_o
);

  logic [SH:0]   mg [0:MMAX];
  logic [XW-1:0] scaled;

  assign mg[0] = '0;
  for (genvar d = 1; d <= MMAX; d++) begin : g_magic
    assign mg[d] = (SH+1)'(recip_magic(SH, d));
  end

  assign scaled = XW'(w_i) * XW'(num_i);
  assign w_o    = WW'((PW'(scaled) * PW'(mg[den_i])) >> SH);

endmodule

// File: rtl/mrg_sequencer.sv
module mrg_sequencer
  import mrg_pkg::*;
#(
  parameter int NDIG = 4,
  parameter int MW   = 3,
  parameter int WW   = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NDIG*MW-1:0]        mult_i,
  input  logic [1:0]                trim_i,
  input  logic [NDIG*MW:0]          ofs_i,
  input  logic [NDIG*MW:0]          len_i,
  output logic                      busy_o,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NDIG*MW-1:0]        out_digits,
  output logic [$clog2(NDIG)-1:0]   out_idx,
  output logic                      out_up,
  output logic                      out_moved,
  output logic                      out_neg,
  output logic [WW-1:0]             out_weight,
  output logic                      out_last,
  output logic                      done_o
);

  localparam int CW = NDIG*MW+1;
  localparam int FW = $clog2(NDIG+1);
  localparam int IW = $clog2(NDIG);

  typedef logic [NDIG-1:0][MW-1:0] dig_t;

  seq_state_e          st;
  dig_t                m_eff_q, a_q, a_n, m_next;
  logic [NDIG-1:0]     o_q, o_n;
  logic [NDIG:0][FW-1:0] f_q, f_n;
  logic [WW-1:0]       w_q, w_n;
  logic                neg_q, up_q, up_n, moved_q, done_q;
  logic [IW-1:0]       idx_q, j_n;
  logic [MW-1:0]       num_n, den_n;
  logic [CW-1:0]       rank, ofs_r, end_r, total_m1, total_next, end_calc;
  logic [CW:0]         ofs_plus_len;

  gs_trim #(.NDIG(NDIG), .MW(MW)) trim_u (
    .mult_i (mult_i),
    .trim_i (trim_i),
    .m_eff_o(m_next),
    .total_o(total_next)
  );

  gs_step #(.NDIG(NDIG), .MW(MW)) step_u (
    .m_i  (m_eff_q),
    .a_i  (a_q),
    .o_i  (o_q),
    .f_i  (f_q),
    .a_o  (a_n),
    .o_o  (o_n),
    .f_o  (f_n),
    .j_o  (j_n),
    .up_o (up_n),
    .num_o(num_n),
    .den_o(den_n)
  );

  gs_weight #(.MW(MW), .WW(WW)) weight_u (
    .w_i  (w_q),
    .num_i(num_n),
    .den_i(den_n),
    .w_o  (w_n)
  );

  // Last rank of the slice, clipped to the end of the sequence
  assign ofs_plus_len = {1'b0, ofs_i} + {1'b0, len_i};
  always_comb begin
    if (len_i == '0 || ofs_plus_len >= {1'b0, total_next}) end_calc = total_next - CW'(1);
    else                                                   end_calc = CW'(ofs_plus_len - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      m_eff_q  <= '0;
      a_q      <= '0;
      o_q      <= '1;
      f_q      <= '0;
      w_q      <= WW'(1);
      neg_q    <= 1'b0;
      up_q     <= 1'b0;
      moved_q  <= 1'b0;
      idx_q    <= '0;
      rank     <= '0;
      ofs_r    <= '0;
      end_r    <= '0;
      total_m1 <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            m_eff_q  <= m_next;
            total_m1 <= total_next - CW'(1);
            a_q      <= '0;
            o_q      <= '1;
            for (int k = 0; k <= NDIG; k++) f_q[k] <= FW'(k);
            w_q      <= WW'(1);
            neg_q    <= 1'b0;
            up_q     <= 1'b0;
            moved_q  <= 1'b0;
            idx_q    <= '0;
            rank     <= '0;
            ofs_r    <= ofs_i;
            end_r    <= end_calc;
            st       <= (ofs_i == '0) ? SEQ_EMIT : SEQ_SKIP;
          end
        end
        SEQ_SKIP: begin
          if (rank == total_m1) begin
            st     <= SEQ_IDLE;
            done_q <= 1'b1;
          end else begin
            a_q     <= a_n;
            o_q     <= o_n;
            f_q     <= f_n;
            w_q     <= w_n;
            neg_q   <= ~neg_q;
            rank    <= rank + CW'(1);
            moved_q <= 1'b1;
            idx_q   <= j_n;
            up_q    <= up_n;
            if (rank + CW'(1) == ofs_r) st <= SEQ_EMIT;
          end
        end
        SEQ_EMIT: begin
          if (out_ready) begin
            if (rank == end_r) begin
              st     <= SEQ_IDLE;
              done_q <= 1'b1;
            end else begin
              a_q     <= a_n;
              o_q     <= o_n;
              f_q     <= f_n;
              w_q     <= w_n;
              neg_q   <= ~neg_q;
              rank    <= rank + CW'(1);
              moved_q <= 1'b1;
              idx_q   <= j_n;
              up_q    <= up_n;
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != SEQ_IDLE);
  assign out_valid  = (st == SEQ_EMIT);
  assign out_last   = (st == SEQ_EMIT) && (rank == end_r);
  assign out_digits = a_q;
  assign out_idx    = idx_q;
  assign out_up     = up_q;
  assign out_moved  = moved_q;
  assign out_neg    = neg_q;
  assign out_weight = w_q;
  assign done_o     = done_q;

endmodule

// File: rtl/mrg_seq_checker.sv
module mrg_seq_checker #(
  parameter int NDIG = 4,
  parameter int MW   = 3,
  parameter int WW   = 24,
  localparam int IW  = $clog2(NDIG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NDIG*MW-1:0] out_digits,
  input logic [IW-1:0]      out_idx,
  input logic               out_up,
  input logic               out_moved,
  input logic               out_neg,
  input logic [WW-1:0]      out_weight,
  input logic               out_last,
  input logic               done_o,
  input logic               busy_o,
  input logic [NDIG*MW-1:0] m_eff
);

  logic [NDIG*MW-1:0] prev_q;
  logic               step_ok, in_range, parity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= out_digits;
  end

  always_comb begin
    int ndiff;
    logic bad;
    logic [MW-1:0] cur, pr;
    ndiff    = 0;
    bad      = 1'b0;
    in_range = 1'b1;
    parity   = 1'b0;
    for (int k = 0; k < NDIG; k++) begin
      cur = out_digits[k*MW +: MW];
      pr  = prev_q[k*MW +: MW];
      parity = parity ^ cur[0];
      if (cur > m_eff[k*MW +: MW]) in_range = 1'b0;
      if (cur != pr) begin
        ndiff++;
        if (IW'(k) != out_idx) bad = 1'b1;
        if (out_up && cur != pr + MW'(1)) bad = 1'b1;
        if (!out_up && cur + MW'(1) != pr) bad = 1'b1;
      end
    end
    step_ok = (ndiff == 1) && !bad;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_digits) && $stable(out_weight)
      && $stable(out_neg) && $stable(out_idx) && $stable(out_up) && $stable(out_last));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_moved && step_ok);

  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_range);

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_moved |-> out_digits == '0 && out_weight == WW'(1) && !out_neg);

  assert_sign_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_neg == parity);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !out_valid);

endmodule

bind mrg_sequencer mrg_seq_checker #(.NDIG(NDIG), .MW(MW), .WW(WW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_digits(out_digits),
  .out_idx   (out_idx),
  .out_up    (out_up),
  .out_moved (out_moved),
  .out_neg   (out_neg),
  .out_weight(out_weight),
  .out_last  (out_last),
  .done_o    (done_o),
  .busy_o    (busy_o),
  .m_eff     (m_eff_q)
);

// File: tb/mrg_sequencer_tb_top.sv
module mrg_sequencer_tb_top;

  localparam int NDIG = 4;
  localparam int MW   = 3;
  localparam int WW   = 24;
  localparam int CW   = NDIG*MW+1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NDIG*MW-1:0] mult_i = '0;
  logic [1:0] trim_i = '0;
  logic [CW-1:0] ofs_i = '0, len_i = '0;
  logic busy_o, out_valid, out_up, out_moved, out_neg, out_last, done_o;
  logic out_ready = 1'b0;
  logic [NDIG*MW-1:0] out_digits;
  logic [1:0] out_idx;
  logic [WW-1:0] out_weight;

  int checks = 0, errors = 0, cycles = 0;
  int effm [NDIG];
  int total;

  always #5 clk = ~clk;

  mrg_sequencer #(.NDIG(NDIG), .MW(MW), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mult_i(mult_i), .trim_i(trim_i),
    .ofs_i(ofs_i), .len_i(len_i), .busy_o(busy_o), .out_valid(out_valid),
    .out_ready(out_ready), .out_digits(out_digits), .out_idx(out_idx),
    .out_up(out_up), .out_moved(out_moved), .out_neg(out_neg),
    .out_weight(out_weight), .out_last(out_last), .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=180000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int binom(input int m, input int k);
    int r = 1;
    for (int i = 1; i <= k; i++) r = r * (m - k + i) / i;
    return r;
  endfunction

  function automatic logic [NDIG*MW-1:0] pack4(input int d0, d1, d2, d3);
    return {MW'(d3), MW'(d2), MW'(d1), MW'(d0)};
  endfunction

  // Effective multiplicities: zero clamps to one (R10), smallest trimmed not below 1 (R5)
  task automatic set_eff(input logic [NDIG*MW-1:0] mv, input int tr);
    int bi = 0;
    for (int k = 0; k < NDIG; k++) begin
      effm[k] = int'(mv[k*MW +: MW]);
      if (effm[k] == 0) effm[k] = 1;
    end
    for (int k = 1; k < NDIG; k++) if (effm[k] < effm[bi]) bi = k;
    effm[bi] = (effm[bi] > tr) ? effm[bi] - tr : 1;
    total = 1;
    for (int k = 0; k < NDIG; k++) total = total * (effm[k] + 1);
  endtask

  // Rank to codeword by mixed-radix digits with reflection (R3)
  function automatic logic [NDIG*MW-1:0] code_at(input int rank);
    logic [NDIG*MW-1:0] c = '0;
    int r = rank;
    for (int k = 0; k < NDIG; k++) begin
      int b = r % (effm[k] + 1);
      int hi = r / (effm[k] + 1);
      c[k*MW +: MW] = MW'((hi % 2 == 0) ? b : effm[k] - b);
      r = hi;
    end
    return c;
  endfunction

  task automatic check_word(input int r);
    logic [NDIG*MW-1:0] c, p;
    longint w = 1;
    int par = 0, eidx = 0, eup = 0;
    c = code_at(r);
    for (int k = 0; k < NDIG; k++) begin
      int d = int'(c[k*MW +: MW]);
      w = w * binom(effm[k], d);
      par = par ^ (d & 1);
    end
    chk(out_digits == c, "R3 codeword", out_digits, c);
    chk(out_weight == WW'(w) && out_neg == par[0], "R4 weight/sign",
        {out_neg, out_weight}, {par[0], WW'(w)});
    if (r == 0) begin
      chk(!out_moved, "R2 first word", out_moved, 0);
    end else begin
      p = code_at(r - 1);
      for (int k = 0; k < NDIG; k++)
        if (c[k*MW +: MW] != p[k*MW +: MW]) begin
          eidx = k;
          eup = (c[k*MW +: MW] > p[k*MW +: MW]) ? 1 : 0;
        end
      chk(out_moved && out_idx == 2'(eidx) && out_up == eup[0], "R3 step idx/dir",
          {out_moved, out_idx, out_up}, {1'b1, 2'(eidx), eup[0]});
    end
  endtask

  task automatic run_slice(input logic [NDIG*MW-1:0] mv, input int tr, input int ofs,
                           input int len, input int mode, input bit poke);
    int r, endx, cyc;
    bit got_done, pend_last, hold;
    logic [NDIG*MW+WW+4:0] saved;
    set_eff(mv, tr);
    endx = (len == 0 || ofs + len > total) ? total : ofs + len;
    if (ofs >= total) endx = ofs;
    @(negedge clk);
    mult_i = mv; trim_i = 2'(tr); ofs_i = CW'(ofs); len_i = CW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    r = ofs; cyc = 0; got_done = 0; pend_last = 0; hold = 0;
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) begin start = 1'b1; mult_i = '0; ofs_i = '0; end
      if (poke && cyc == 6) start = 1'b0;
      if (pend_last) chk(done_o == 1'b1, "R7 done after last", done_o, 1);
      if (done_o) begin
        got_done = 1;
        chk(busy_o == 1'b0, "R9 idle at done", busy_o, 0);
      end else begin
        if (hold)
          chk(out_valid && {out_digits, out_weight, out_neg, out_idx, out_up, out_last} == saved,
              "R8 stall hold", {out_digits, out_weight}, saved);
        hold = 0;
        if (out_valid) begin
          out_ready = (mode == 0) ? 1'b1 : ($urandom % 3 != 0);
          if (out_ready) begin
            check_word(r);
            chk(out_last == (r == endx - 1), "R7 last flag", out_last, (r == endx - 1));
            pend_last = (r == endx - 1);
            r++;
          end else begin
            saved = {out_digits, out_weight, out_neg, out_idx, out_up, out_last};
            hold = 1;
          end
        end else begin
          out_ready = 1'b0;
        end
      end
    end
    out_ready = 1'b0;
    chk(got_done, "R7 done seen", got_done, 1);
    chk(r == endx, "R6 codeword count", r, endx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy_o && !done_o, "R1 reset state", {out_valid, busy_o, done_o}, 0);
    rst_n = 1'b1;
    // all multiplicities 1: binary reflected code (R2 R3 R4)
    run_slice(pack4(1, 1, 1, 1), 0, 0, 0, 0, 0);
    // mixed radices with random stalls (R8)
    run_slice(pack4(3, 2, 4, 1), 0, 0, 0, 1, 0);
    // every rank of the largest configuration
    run_slice(pack4(7, 7, 7, 7), 0, 0, 0, 0, 0);
    // four staggered slices covering one sequence (R6)
    for (int s = 0; s < 4; s++) run_slice(pack4(2, 3, 2, 3), 0, s * 36, 36, 1, 0);
    // trim (R5) and zero clamp (R10)
    run_slice(pack4(5, 2, 6, 2), 3, 0, 0, 0, 0);
    run_slice(pack4(6, 5, 4, 7), 2, 0, 0, 1, 0);
    run_slice(pack4(0, 2, 0, 3), 0, 0, 0, 0, 0);
    // slice clipping and empty slice (R6)
    run_slice(pack4(3, 2, 4, 1), 0, 50, 0, 0, 0);
    run_slice(pack4(3, 2, 4, 1), 0, 100, 50, 1, 0);
    run_slice(pack4(3, 2, 4, 1), 0, 120, 5, 0, 0);
    // start pulse while busy has no effect (R9)
    run_slice(pack4(2, 2, 2, 2), 0, 3, 40, 1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule